// File: doc/BRIEF.md
# Interrupt Pending and Priority Arbiter

This block gathers level-sensitive interrupt request lines into a pending-status word, filters that word through a locally enabled mask, and decides whether the core should take an interrupt now. Each line reports its level through a small event port that carries a line index and a level. The stored bit for that line then follows the reported level; it is not an edge latch. The two lowest lines are software interrupts, and a status write port can also set or clear them.

A take is delivered only when the global interrupt enable is set and the core is not in debug state. The wake indication ignores both of those gates, so a halted core can resume even while delivery is blocked. The highest-numbered enabled pending line wins. The winning index and the take flag are registered, so a line that falls in the same cycle that its request is taken cannot make the index glitch.

Top module: `irq_pend_arb`

## Requirements
- R1: A valid event whose index is below the line count (13) stores its level in that pending bit at the next clock edge. The bit keeps that value until the next event or software write that targets it.
- R2: An event whose index is 13 or more changes no pending bit and no output.
- R3: `hw_req` is 1 exactly when any pending bit is 1, whatever the enable mask, global enable and debug flag are.
- R4: A software write loads `sw_wdata` into pending bits 0 and 1 at the next edge and leaves bits 2..12 unchanged. If a valid event targets bit 0 or 1 in the same cycle, the event's level wins for that bit.
- R5: `take` is 1 in the cycle after a cycle in which (pending AND mask) was nonzero, `gie` was 1 and `dbg_mode` was 0. Otherwise `take` is 0.
- R6: `vec_idx` is registered together with `take`. It holds the highest-numbered bit set in the masked word of the previous cycle when `take` is 1, and it is 0 when `take` is 0.
- R7: `wake` is 1 exactly when `hw_req` is 1 and (pending AND mask) is nonzero. It does not depend on `gie` or `dbg_mode`.
- R8: While `rst_n` is low at a clock edge, all pending bits, the enable mask, `take` and `vec_idx` are cleared.
- R9: `en_we` loads `en_wdata` into the enable mask at the next edge. Bit i of the mask enables line i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | A line level report is present this cycle |
| evt_idx | input | 5 | Line index of the report; values of 13 or more are ignored |
| evt_level | input | 1 | Reported level of that line |
| sw_we | input | 1 | Write strobe for the software pending bits |
| sw_wdata | input | 2 | New values for pending bits 0 and 1 |
| en_we | input | 1 | Write strobe for the enable mask |
| en_wdata | input | 13 | New enable mask |
| gie | input | 1 | Global interrupt enable |
| dbg_mode | input | 1 | Core is in debug state; blocks delivery |
| pend_stat | output | 13 | Pending-status word |
| hw_req | output | 1 | Some line is pending |
| wake | output | 1 | An enabled line is pending |
| take | output | 1 | Registered take-interrupt request |
| vec_idx | output | 4 | Registered index of the winning line |

## Verification
Two update paths can fall in the same cycle: a software write to the low status bits and a level report that targets one of those bits. The bench drives both on the same edge, including a report that clears bit 0 while the write sets it. It then compares the stored word against a bench model in which the report overrides the write for its own bit. A second overlap is a falling line at the edge where a take is registered. The bench checks that the index still names the line that won in the previous cycle, and that the next cycle shows the new winner.

// File: rtl/irq_arb_pkg.sv
// Shared constants and helpers for the interrupt pending/priority arbiter.
// Assumes at least two lines and at most 31.
package irq_arb_pkg;
    localparam int DEF_LINES = 13;
    localparam int DEF_SW    = 2;

    // Width of the event index port: one bit wider than a line index, so
    // that out-of-range indices can be presented.
    function automatic int evt_width(input int lines);
        return $clog2(lines) + 1;
    endfunction
endpackage

// File: rtl/irq_pend_store.sv
// Pending-status and enable-mask registers.
// Assumes: the event port reports levels; events win over a software write
// on the same bit; the reset is synchronous and active low.
module irq_pend_store #(
    parameter int NUM_LINES = 13,
    parameter int SW_LINES  = 2,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int EVT_W    = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic [EVT_W-1:0]     evt_idx,
    input  logic                 evt_level,
    input  logic                 sw_we,
    input  logic [SW_LINES-1:0]  sw_wdata,
    input  logic                 en_we,
    input  logic [NUM_LINES-1:0] en_wdata,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [NUM_LINES-1:0] mask_q
);
    logic                 evt_hit;
    logic [NUM_LINES-1:0] pend_d;

    // Decide whether the event addresses an existing line.
    assign evt_hit = evt_valid && (int'(evt_idx) < NUM_LINES);

    // Next pending word: software write first, then the event overrides its bit.
    always_comb begin
        pend_d = pend_q;
        if (sw_we) begin
            pend_d[SW_LINES-1:0] = sw_wdata;
        end
        if (evt_hit) begin
            pend_d[evt_idx[IDX_W-1:0]] = evt_level;
        end
    end

    // Pending register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    // Enable-mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (en_we) begin
            mask_q <= en_wdata;
        end
    end

    assert_evt_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        evt_hit |=> pend_q[$past(evt_idx[IDX_W-1:0])] == $past(evt_level))
        else $error("R1: pending bit does not follow reported level");

    assert_oob_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_hit && !sw_we) |=> $stable(pend_q))
        else $error("R2: out-of-range event changed pending state");

    assert_hw_bits_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_hit |=> pend_q[NUM_LINES-1:SW_LINES] == $past(pend_q[NUM_LINES-1:SW_LINES]))
        else $error("R4: hardware bits changed without an event");

    assert_mask_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> mask_q == $past(en_wdata))
        else $error("R9: mask not loaded");
endmodule

// File: rtl/irq_prio_enc.sv
// Highest-set-bit priority encoder; returns 0 for an all-zero word.
// Purely combinational.
module irq_prio_enc #(
    parameter int NUM_LINES = 13,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] vec,
    output logic [IDX_W-1:0]     idx
);
    // Scan upward so that the last (highest) set bit is kept.
    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    // R6: the chosen bit is set and nothing above it is.
    always_comb begin
        if (vec != '0) begin
            assert_winner_top_R6: assert ((vec >> idx) == 1)
                else $error("R6: encoder did not pick the highest bit");
        end
    end
endmodule

// File: rtl/irq_take_stage.sv
// Registers the take request and the winning index for one cycle.
// Assumes that the masked word and the gates are stable before the clock edge.
module irq_take_stage #(
    parameter int NUM_LINES = 13,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] masked,
    input  logic [IDX_W-1:0]     win_idx,
    input  logic                 gie,
    input  logic                 dbg_mode,
    output logic                 take_q,
    output logic [IDX_W-1:0]     vec_q
);
    logic deliver;

    // Delivery gate: something enabled is pending, global enable on, not in debug.
    assign deliver = (|masked) && gie && !dbg_mode;

    // Capture take and index together; the index is zero when nothing is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            take_q <= deliver;
            vec_q  <= deliver ? win_idx : '0;
        end
    end

    assert_take_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |-> $past(gie && !dbg_mode && (masked != '0)))
        else $error("R5: take without a deliverable line");

    assert_vec_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |-> (($past(masked) >> vec_q) == 1))
        else $error("R6: index is not the highest enabled line");

    assert_vec_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !take_q |-> vec_q == '0)
        else $error("R6: index nonzero without take");
endmodule

// File: rtl/irq_pend_arb.sv
// Interrupt pending and priority arbiter (top).
// Collects line levels into a pending word, masks it, and produces a
// registered take plus winning index. The wake output ignores the global
// enable and the debug flag. Synchronous active-low reset.
module irq_pend_arb
    import irq_arb_pkg::*;
#(
    parameter int NUM_LINES = DEF_LINES,
    parameter int SW_LINES  = DEF_SW,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int EVT_W    = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic [EVT_W-1:0]     evt_idx,
    input  logic                 evt_level,
    input  logic                 sw_we,
    input  logic [SW_LINES-1:0]  sw_wdata,
    input  logic                 en_we,
    input  logic [NUM_LINES-1:0] en_wdata,
    input  logic                 gie,
    input  logic                 dbg_mode,
    output logic [NUM_LINES-1:0] pend_stat,
    output logic                 hw_req,
    output logic                 wake,
    output logic                 take,
    output logic [IDX_W-1:0]     vec_idx
);
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] masked;
    logic [IDX_W-1:0]     win_idx;

    irq_pend_store #(.NUM_LINES(NUM_LINES), .SW_LINES(SW_LINES)) store_i (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_idx(evt_idx), .evt_level(evt_level),
        .sw_we(sw_we), .sw_wdata(sw_wdata),
        .en_we(en_we), .en_wdata(en_wdata),
        .pend_q(pend_q), .mask_q(mask_q)
    );

    // Masked pending word feeding the encoder and the wake logic.
    assign masked = pend_q & mask_q;

    irq_prio_enc #(.NUM_LINES(NUM_LINES)) enc_i (
        .vec(masked), .idx(win_idx)
    );

    irq_take_stage #(.NUM_LINES(NUM_LINES)) take_i (
        .clk(clk), .rst_n(rst_n), .masked(masked), .win_idx(win_idx),
        .gie(gie), .dbg_mode(dbg_mode), .take_q(take), .vec_q(vec_idx)
    );

    // Status, request and wake outputs.
    assign pend_stat = pend_q;
    assign hw_req    = |pend_q;
    assign wake      = hw_req && (|masked);

    assert_req_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hw_req) |-> $past(evt_valid || sw_we))
        else $error("R3: request rose with no update");

    assert_wake_ungated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_mode && hw_req && (|masked)) |-> wake)
        else $error("R7: wake blocked by debug state");
endmodule

// File: tb/irq_pend_arb_tb.sv
// Self-checking bench: sweeps pending patterns, masks and gate settings
// against an arithmetic model.
module irq_pend_arb_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [4:0]  evt_idx = '0;
    logic        evt_level = 1'b0;
    logic        sw_we = 1'b0;
    logic [1:0]  sw_wdata = '0;
    logic        en_we = 1'b0;
    logic [N-1:0] en_wdata = '0;
    logic        gie = 1'b0;
    logic        dbg_mode = 1'b0;
    logic [N-1:0] pend_stat;
    logic        hw_req, wake, take;
    logic [3:0]  vec_idx;

    int n_chk = 0;
    int n_bad = 0;
    logic [N-1:0] m_pend = '0;
    logic [N-1:0] m_mask = '0;
    bit done = 0;

    irq_pend_arb dut_i (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_idx(evt_idx),
        .evt_level(evt_level), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .en_we(en_we), .en_wdata(en_wdata), .gie(gie), .dbg_mode(dbg_mode),
        .pend_stat(pend_stat), .hw_req(hw_req), .wake(wake), .take(take),
        .vec_idx(vec_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic ev(input int idx, input bit lvl);
        evt_valid = 1'b1; evt_idx = 5'(idx); evt_level = lvl;
        step();
        evt_valid = 1'b0;
        if (idx < N) m_pend[idx] = lvl;
    endtask

    task automatic set_mask(input logic [N-1:0] m);
        en_we = 1'b1; en_wdata = m;
        step();
        en_we = 1'b0;
        m_mask = m;
    endtask

    task automatic load_pattern(input logic [N-1:0] p);
        for (int i = 0; i < N; i++) begin
            if (m_pend[i] != p[i]) ev(i, p[i]);
        end
    endtask

    // Let one edge pass with inputs held, then compare every output.
    task automatic check_all(input string ctx);
        logic [N-1:0] mk;
        int hi;
        bit exp_take;
        step();
        mk = m_pend & m_mask;
        hi = 0;
        for (int i = 0; i < N; i++) if (mk[i]) hi = i;
        exp_take = (mk != 0) && gie && !dbg_mode;
        chk({"R1 pend ", ctx}, int'(pend_stat), int'(m_pend));
        chk({"R3 hw_req ", ctx}, int'(hw_req), int'(m_pend != 0));
        chk({"R7 wake ", ctx}, int'(wake), int'((m_pend != 0) && (mk != 0)));
        chk({"R5 take ", ctx}, int'(take), int'(exp_take));
        chk({"R6 vec ", ctx}, int'(vec_idx), exp_take ? hi : 0);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d expected < 150000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [N-1:0] p;
        logic [N-1:0] m;
        @(negedge clk);
        step(); step();
        // R8: reset state
        chk("R8 pend after reset", int'(pend_stat), 0);
        chk("R8 take after reset", int'(take), 0);
        chk("R8 vec after reset", int'(vec_idx), 0);
        chk("R3 hw_req after reset", int'(hw_req), 0);
        rst_n = 1'b1;
        step();

        // R1/R3: each line alone, unmasked; request raised regardless of enables
        for (int i = 0; i < N; i++) begin
            ev(i, 1'b1);
            check_all("single line on");
            ev(i, 1'b0);
            check_all("single line off");
        end

        // R2: out-of-range indices change nothing
        load_pattern(13'h0A5A);
        set_mask(13'h1FFF);
        gie = 1'b1;
        for (int i = N; i < 32; i++) begin
            ev(i, 1'b1);
            chk("R2 out-of-range set", int'(pend_stat), 13'h0A5A);
            ev(i, 1'b0);
        end
        check_all("R2 after out-of-range");

        // R9/R5/R6/R7: sweep pending patterns, masks and gates
        for (int k = 0; k < 8192; k += 29) begin
            p = 13'(k);
            m = 13'((k * 7919) ^ 13'h155);
            load_pattern(p);
            set_mask(m);
            for (int g = 0; g < 4; g++) begin
                gie = g[0];
                dbg_mode = g[1];
                check_all("sweep");
            end
        end
        dbg_mode = 1'b0;

        // R4: software write touches only bits 0..1
        load_pattern(13'h1FFC);
        sw_we = 1'b1; sw_wdata = 2'b10;
        step();
        sw_we = 1'b0;
        m_pend[1:0] = 2'b10;
        chk("R4 sw write bits", int'(pend_stat), 13'h1FFE);
        sw_we = 1'b1; sw_wdata = 2'b01;
        step();
        sw_we = 1'b0;
        m_pend[1:0] = 2'b01;
        chk("R4 sw write keeps hw bits", int'(pend_stat), 13'h1FFD);

        // R4: event and software write on the same bit in one cycle, event wins
        sw_we = 1'b1; sw_wdata = 2'b11;
        evt_valid = 1'b1; evt_idx = 5'd0; evt_level = 1'b0;
        step();
        sw_we = 1'b0; evt_valid = 1'b0;
        m_pend[1:0] = 2'b10;
        chk("R4 event overrides sw write", int'(pend_stat), 13'h1FFE);

        // R6: falling winner at the take edge keeps the registered index
        load_pattern(13'h0012);
        set_mask(13'h1FFF);
        gie = 1'b1;
        step();
        ev(4, 1'b0); // take registered with line 4 winning at this edge
        chk("R6 index held through fall", int'(vec_idx), 4);
        chk("R5 take held through fall", int'(take), 1);
        step();
        chk("R6 index after fall", int'(vec_idx), 1);

        // R7: debug blocks take, not wake
        dbg_mode = 1'b1;
        check_all("R7 debug");
        dbg_mode = 1'b0;

        // R8: mid-run reset clears pending and mask
        load_pattern(13'h0300);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        m_pend = '0; m_mask = '0;
        chk("R8 pend cleared", int'(pend_stat), 0);
        ev(9, 1'b1);
        check_all("R8 mask cleared, no take");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule